// File: doc/BRIEF.md
# Memory Page Protection Checker

This block sits between the requesters of a paged local memory and the memory array. Every request gives an initiator privilege ID, an address, a read/write type, a flag for direct CPU accesses (clear for DMA and system-master traffic), and the privilege mode of the issuing CPU. The upper address bits select a page. Each page has one access enable bit for each access ID and one local bit. The checker combines them to allow or block the access in the same cycle, and it gates the memory write and read strobes.

The result comes back one cycle later with the read data. A blocked read returns zero. A blocked write never reaches the memory. The first violation is captured in a fault log that holds the initiator, address, access type and resolved privilege mode, and it raises a one-cycle interrupt event. The log holds until software clears it. Later violations while the log is full only set a sticky overflow flag.

Top module: `page_guard`

## Requirements
- R1: The page index is the top $clog2(NUM_PAGES) bits of `req_addr`. The page's access enable bit for privilege ID p is `page_aid_en[page*NUM_AID + p]`, and its local bit is `page_local[page]`.
- R2: A request with `req_cpu_direct`=1 is allowed exactly when the page's local bit is 1. Any other request is allowed exactly when the page's enable bit for `req_pid` is 1. A privilege ID of NUM_AID or more has no enable bit and counts as 0.
- R3: In the request cycle, `mem_we` is 1 only for a valid, allowed write and `mem_re` is 1 only for a valid, allowed read. A blocked access drives neither strobe.
- R4: One cycle after a request, `resp_valid` is 1 and `resp_granted` shows the decision. `resp_rdata` carries the `mem_rdata` of the request cycle for an allowed read and zero in every other case.
- R5: A violation that arrives while the log is empty latches `fault_pid`, `fault_addr`, `fault_write` and `fault_user` and sets `fault_valid` at the next edge. `fault_event` is 1 for exactly that one cycle.
- R6: `fault_user` is 1 for privilege IDs 3 and above. For IDs 0 to 2 it is the inverse of `req_cpu_super`.
- R7: While `fault_valid` is 1 and `log_clear` is 0, a new violation leaves the logged fields unchanged, sets `fault_overflow`, and raises no event. The log and the overflow flag stay set until cleared.
- R8: `log_clear` empties the log and the overflow flag at the next edge. A violation in the same cycle is logged as a fresh first fault and raises the event.
- R9: After reset, all registered outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cpu_direct | input | 1 | Direct CPU access (0 = DMA or system master) |
| req_cpu_super | input | 1 | Issuing CPU is in supervisor mode |
| req_pid | input | PID_W | Initiator privilege ID |
| req_addr | input | ADDR_W | Access byte address |
| mem_rdata | input | DATA_W | Read data from the array in the request cycle |
| page_aid_en | input | NUM_PAGES*NUM_AID | Per-page access enable bits |
| page_local | input | NUM_PAGES | Per-page local bits |
| log_clear | input | 1 | Software clear of the fault log |
| mem_we | output | 1 | Write strobe to the array |
| mem_re | output | 1 | Read strobe to the array |
| resp_valid | output | 1 | Response for the previous cycle's request |
| resp_granted | output | 1 | Previous request was allowed |
| resp_rdata | output | DATA_W | Read data, zero unless an allowed read |
| fault_event | output | 1 | One-cycle interrupt event on a logged fault |
| fault_valid | output | 1 | Fault log holds an entry |
| fault_overflow | output | 1 | Further violations since the log filled |
| fault_pid | output | PID_W | Logged privilege ID |
| fault_addr | output | ADDR_W | Logged address |
| fault_write | output | 1 | Logged access was a write |
| fault_user | output | 1 | Logged access was in user mode |

## Verification
The bench sets up all four combinations of enable and local bit against direct and indirect requests. A checker that swapped the roles of the two bits would let DMA traffic through a page marked for the CPU only. It uses privilege IDs 6 and 7, where a checker that indexed past the table would read a neighbouring page's bit. It also sends a burst of violations while the log is full, where a design that overwrote the log would lose the first initiator. A clear in the same cycle as a new violation is tested, where a wrong priority would drop that fault or leave a stale overflow flag. Random traffic also checks that a blocked read returns zero even when the array drives data.

// File: rtl/page_guard.sv
module page_guard #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int NUM_PAGES = 16,
  parameter int NUM_AID   = 6,
  parameter int PID_W     = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  input  logic                           req_write,
  input  logic                           req_cpu_direct,
  input  logic                           req_cpu_super,
  input  logic [PID_W-1:0]               req_pid,
  input  logic [ADDR_W-1:0]              req_addr,
  input  logic [DATA_W-1:0]              mem_rdata,
  input  logic [NUM_PAGES*NUM_AID-1:0]   page_aid_en,
  input  logic [NUM_PAGES-1:0]           page_local,
  input  logic                           log_clear,
  output logic                           mem_we,
  output logic                           mem_re,
  output logic                           resp_valid,
  output logic                           resp_granted,
  output logic [DATA_W-1:0]              resp_rdata,
  output logic                           fault_event,
  output logic                           fault_valid,
  output logic                           fault_overflow,
  output logic [PID_W-1:0]               fault_pid,
  output logic [ADDR_W-1:0]              fault_addr,
  output logic                           fault_write,
  output logic                           fault_user
);
  localparam int PG_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;

  logic [PG_W-1:0] page;
  logic aid_bit, local_bit, allow, violation, user_mode, log_open;

  assign page = req_addr[ADDR_W-1 -: PG_W];

  always_comb begin
    aid_bit = 1'b0;
    if (int'(req_pid) < NUM_AID)
      aid_bit = page_aid_en[int'(page) * NUM_AID + int'(req_pid)];
  end

  assign local_bit = page_local[page];
  assign allow     = req_cpu_direct ? local_bit : aid_bit;
  assign violation = req_valid & ~allow;
  assign user_mode = (req_pid >= PID_W'(3)) | ~req_cpu_super;
  assign log_open  = ~fault_valid | log_clear;

  assign mem_we = req_valid & allow & req_write;
  assign mem_re = req_valid & allow & ~req_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid   <= 1'b0;
      resp_granted <= 1'b0;
      resp_rdata   <= '0;
    end else begin
      resp_valid   <= req_valid;
      resp_granted <= req_valid & allow;
      resp_rdata   <= mem_re ? mem_rdata : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_event    <= 1'b0;
      fault_valid    <= 1'b0;
      fault_overflow <= 1'b0;
      fault_pid      <= '0;
      fault_addr     <= '0;
      fault_write    <= 1'b0;
      fault_user     <= 1'b0;
    end else begin
      fault_event <= violation & log_open;
      if (log_clear) begin
        fault_valid    <= 1'b0;
        fault_overflow <= 1'b0;
      end
      if (violation && log_open) begin
        fault_valid <= 1'b1;
        fault_pid   <= req_pid;
        fault_addr  <= req_addr;
        fault_write <= req_write;
        fault_user  <= user_mode;
      end else if (violation) begin
        fault_overflow <= 1'b1;
      end
    end
  end

  assert_strobe_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we | mem_re) |-> (req_valid && (mem_we == req_write)));
  assert_strobes_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  assert_resp_follows_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  assert_denied_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_granted) |-> (resp_rdata == '0));
  assert_event_with_log_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_event |-> fault_valid);
  assert_log_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && !log_clear) |=> (fault_valid && !fault_event && $stable(fault_addr) && $stable(fault_pid)));
  assert_overflow_needs_log_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_overflow |-> fault_valid);
  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (log_clear && !req_valid) |=> (!fault_valid && !fault_overflow));
endmodule

// File: tb/test_page_guard.sv
module test_page_guard;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16, DATA_W = 32, NUM_PAGES = 16, NUM_AID = 6, PID_W = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_cpu_direct = 0, req_cpu_super = 0, log_clear = 0;
  logic [PID_W-1:0] req_pid = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] mem_rdata = '0;
  logic [NUM_PAGES*NUM_AID-1:0] page_aid_en = '0;
  logic [NUM_PAGES-1:0] page_local = '0;
  logic mem_we, mem_re, resp_valid, resp_granted, fault_event, fault_valid, fault_overflow;
  logic fault_write, fault_user;
  logic [DATA_W-1:0] resp_rdata;
  logic [PID_W-1:0] fault_pid;
  logic [ADDR_W-1:0] fault_addr;

  int checks = 0, errors = 0;
  logic e_rv = 0, e_rg = 0, e_ev = 0, e_fv = 0, e_ov = 0, e_wr = 0, e_us = 0;
  logic [DATA_W-1:0] e_rd = '0;
  logic [PID_W-1:0] e_pid = '0;
  logic [ADDR_W-1:0] e_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PAGES(NUM_PAGES), .NUM_AID(NUM_AID), .PID_W(PID_W)) i_page_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_cpu_direct(req_cpu_direct), .req_cpu_super(req_cpu_super), .req_pid(req_pid),
    .req_addr(req_addr), .mem_rdata(mem_rdata), .page_aid_en(page_aid_en),
    .page_local(page_local), .log_clear(log_clear), .mem_we(mem_we), .mem_re(mem_re),
    .resp_valid(resp_valid), .resp_granted(resp_granted), .resp_rdata(resp_rdata),
    .fault_event(fault_event), .fault_valid(fault_valid), .fault_overflow(fault_overflow),
    .fault_pid(fault_pid), .fault_addr(fault_addr), .fault_write(fault_write),
    .fault_user(fault_user));

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_allow(input logic direct, input logic [PID_W-1:0] pid,
                                     input logic [ADDR_W-1:0] addr);
    int pg = int'(addr >> (ADDR_W - $clog2(NUM_PAGES)));
    if (direct) return page_local[pg];
    if (int'(pid) >= NUM_AID) return 1'b0;
    return page_aid_en[pg*NUM_AID + int'(pid)];
  endfunction

  function automatic logic exp_user(input logic [PID_W-1:0] pid, input logic sup);
    return (pid >= 3) ? 1'b1 : !sup;
  endfunction

  task automatic check_regs();
    chk(resp_valid == e_rv, "R4 resp_valid", resp_valid, e_rv);
    chk(resp_granted == e_rg, "R4 resp_granted", resp_granted, e_rg);
    chk(resp_rdata == e_rd, "R4 resp_rdata", resp_rdata, e_rd);
    chk(fault_event == e_ev, "R5 fault_event", fault_event, e_ev);
    chk(fault_valid == e_fv, "R7 fault_valid", fault_valid, e_fv);
    chk(fault_overflow == e_ov, "R7 fault_overflow", fault_overflow, e_ov);
    if (e_fv) begin
      chk(fault_pid == e_pid, "R5 fault_pid", fault_pid, e_pid);
      chk(fault_addr == e_addr, "R5 fault_addr", fault_addr, e_addr);
      chk(fault_write == e_wr, "R5 fault_write", fault_write, e_wr);
      chk(fault_user == e_us, "R6 fault_user", fault_user, e_us);
    end
  endtask

  task automatic step(input logic v, input logic w, input logic d, input logic s,
                      input logic [PID_W-1:0] pid, input logic [ADDR_W-1:0] addr,
                      input logic [DATA_W-1:0] rd, input logic clr);
    logic al, viol;
    req_valid = v; req_write = w; req_cpu_direct = d; req_cpu_super = s;
    req_pid = pid; req_addr = addr; mem_rdata = rd; log_clear = clr;
    #1;
    al = exp_allow(d, pid, addr);
    viol = v && !al;
    chk(mem_we == (v && al && w), "R2 R3 mem_we", mem_we, v && al && w);
    chk(mem_re == (v && al && !w), "R2 R3 mem_re", mem_re, v && al && !w);
    e_rv = v; e_rg = v && al; e_rd = (v && al && !w) ? rd : '0; e_ev = 1'b0;
    if (clr) begin e_fv = 0; e_ov = 0; end
    if (viol) begin
      if (!e_fv) begin
        e_fv = 1; e_ev = 1; e_pid = pid; e_addr = addr; e_wr = w; e_us = exp_user(pid, s);
      end else e_ov = 1;
    end
    @(posedge clk); @(negedge clk);
    check_regs();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk({resp_valid, resp_granted, fault_event, fault_valid, fault_overflow} == 5'b0, "R9 reset flags",
        {resp_valid, resp_granted, fault_event, fault_valid, fault_overflow}, 0);
    chk(resp_rdata == '0 && fault_addr == '0 && fault_pid == '0, "R9 reset data", resp_rdata, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 R2: page 2 combinations for pid 1: aid bit at 2*6+1, local bit 2
    page_aid_en = '0; page_local = '0;
    step(1, 0, 1, 1, 3'd1, 16'h2010, 32'hAAAA_0001, 0); // both 0, direct -> deny, first fault R5
    step(1, 1, 0, 1, 3'd1, 16'h2020, 32'h0, 0);          // both 0, DMA -> deny, overflow R7
    step(0, 0, 0, 0, 3'd0, 16'h0, 32'h0, 1);             // clear R8
    page_local[2] = 1;
    step(1, 0, 1, 0, 3'd1, 16'h2030, 32'h1234_5678, 0); // local only, direct allowed R2
    step(1, 0, 0, 0, 3'd1, 16'h2034, 32'h1234_5678, 0); // local only, DMA denied; rdata 0 R4
    step(0, 0, 0, 0, 3'd0, 16'h0, 32'h0, 1);
    page_local[2] = 0; page_aid_en[2*NUM_AID+1] = 1;
    step(1, 1, 0, 0, 3'd1, 16'h2040, 32'h0, 0);          // aid only, DMA write allowed
    step(1, 1, 1, 0, 3'd1, 16'h2044, 32'h0, 0);          // aid only, direct write denied
    page_local[2] = 1;
    step(1, 0, 1, 1, 3'd1, 16'h2048, 32'hCAFE_F00D, 1); // both, direct; clear too
    step(1, 0, 0, 1, 3'd1, 16'h204C, 32'hBEEF_0000, 0); // both, DMA
    // R2: pid 6 and 7 have no enable bit even when all bits are set
    page_aid_en = '1; page_local = '0;
    step(1, 0, 0, 1, 3'd6, 16'h5000, 32'h1, 0);
    step(1, 0, 0, 1, 3'd7, 16'h5004, 32'h1, 0);
    // R8: clear together with a new violation logs it fresh
    step(1, 1, 0, 1, 3'd7, 16'hF00C, 32'h0, 1);
    // R6: pid 2 in supervisor vs user
    step(0, 0, 0, 0, 3'd0, 16'h0, 32'h0, 1);
    page_aid_en = '0;
    step(1, 0, 0, 1, 3'd2, 16'h7000, 32'h0, 0);
    step(0, 0, 0, 0, 3'd0, 16'h0, 32'h0, 1);
    step(1, 0, 0, 1, 3'd4, 16'h7004, 32'h0, 0);

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      if (i % 200 == 0) begin
        for (int k = 0; k < NUM_PAGES*NUM_AID; k++) page_aid_en[k] = ($urandom % 4) != 0;
        for (int k = 0; k < NUM_PAGES; k++) page_local[k] = ($urandom % 3) != 0;
      end
      step(($urandom % 5) != 0, $urandom % 2, $urandom % 2, $urandom % 2,
           PID_W'($urandom % 8), ADDR_W'($urandom), $urandom, ($urandom % 13) == 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule